// File: doc/BRIEF.md
# MEI Snoop Response Controller

This block watches transactions that other bus masters place on a shared bus and decides how a write-back data cache, kept coherent with the three-state Modified/Exclusive/Invalid protocol, must react. Each snooped address indexes a direct-mapped tag and state array. The 5-bit transfer-type code and the beat type choose the next line state, whether the snooped master is told to retry, and whether a castout engine must push the dirty line out to memory.

The block also holds the load-reserve reservation (a valid flag and a line address). Some snooped writes cancel it. A line-install port lets the processor side place a tag and state into the array. A combinational probe port reads back the state of any address.

Top module: `snoop_resp_ctl`

## Requirements
- R1: Decoded transfer types are 00110 write-with-kill, 01010 read, 11010 atomic read, 01110 read-for-ownership, 11110 atomic read-for-ownership, and 10010 atomic flush-write. Each atomic variant responds exactly like its plain form.
- R2: A write-with-kill that hits moves the line to Invalid (00) from Exclusive or Modified, with no retry and no push. Hit or miss, it clears the reservation when the reservation's line matches the snooped line.
- R3: A read with snp_burst=0 and snp_ci=1 leaves an Exclusive (01) line Exclusive. On a Modified (11) line it retries, requests a push, and moves the line to Exclusive.
- R4: Any other read (burst, or single-beat cacheable) moves an Exclusive line to Invalid. On a Modified line it retries, requests a push, and moves the line to Invalid.
- R5: Read-for-ownership and atomic flush-write move an Exclusive line to Invalid. On a Modified line they retry, request a push, and move the line to Invalid.
- R6: An atomic flush-write clears the reservation whatever its address. Snoops of other types never clear it, except as R2 states.
- R7: A miss makes no state change and no retry. A miss is a tag mismatch, or a stored state of 00 or 10. Every transfer code outside R1 makes no state change, no retry, no push and no reservation change.
- R8: snp_retry is high for exactly the one cycle after a snoop that needs it. push_req rises in that same cycle and holds, with push_addr stable, until push_ack is seen high. push_addr is the line address with its offset bits zero.
- R9: A snoop that hits a Modified line while push_req is still pending retries, but leaves the line Modified and starts no new push.
- R10: Reservation matching compares line addresses only; the offset bits of both addresses are ignored.
- R11: After reset every line is Invalid, and no reservation, retry or push is active. fill_valid writes the tag and state at the fill index, and is ignored in a cycle with snp_valid high. probe_state gives the stored state when the tag matches and the state is 01 or 11, and 00 otherwise.
- R12: rsv_set loads the reservation with the line of rsv_addr. If the same cycle's snoop clears the reservation, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_valid | input | 1 | Snooped transaction present this cycle |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_tt | input | 5 | Snooped transfer-type code |
| snp_burst | input | 1 | 1 = burst, 0 = single beat |
| snp_ci | input | 1 | 1 = caching-inhibited access |
| snp_retry | output | 1 | Retry response, one cycle after the snoop |
| push_req | output | 1 | Dirty-line push request to the castout engine |
| push_addr | output | ADDR_W | Line address to push |
| push_ack | input | 1 | Castout engine accepts the push |
| fill_valid | input | 1 | Install a line into the array |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_state | input | 2 | State written for the installed line |
| rsv_set | input | 1 | Load the reservation |
| rsv_addr | input | ADDR_W | Address for the reservation |
| rsv_valid | output | 1 | Reservation held |
| rsv_line_addr | output | ADDR_W | Reserved line address, offset zero |
| probe_addr | input | ADDR_W | Address to read back |
| probe_state | output | 2 | State of the probed line |

## Verification
A wrong line state shows on probe_state in the cycle right after the snoop edge. It shows again through the next snoop to that line, as a missing or extra snp_retry one cycle after that snoop. A wrong push decision shows as push_req rising with no retry beside it, or as a second snoop to a busy engine changing the line. A reservation wrongly kept or dropped is visible on rsv_valid one cycle after the snoop, so every error appears within one clock of the snoop that caused it.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam logic [1:0] ST_INV = 2'b00;
  localparam logic [1:0] ST_EXC = 2'b01;
  localparam logic [1:0] ST_MOD = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_KILL,
    OP_READ,
    OP_OWN,
    OP_FLUSH
  } snp_op_e;

  typedef struct packed {
    logic [1:0] nxt;
    logic       upd;
    logic       retry;
    logic       push;
  } snp_resp_t;

  // a line counts as present only in Exclusive or Modified
  function automatic logic state_live(input logic [1:0] st);
    return st[0];
  endfunction

  function automatic snp_op_e decode_tt(input logic [4:0] tt);
    snp_op_e op;
    case (tt)
      5'b00110:          op = OP_KILL;
      5'b01010, 5'b11010: op = OP_READ;
      5'b01110, 5'b11110: op = OP_OWN;
      5'b10010:          op = OP_FLUSH;
      default:           op = OP_NONE;
    endcase
    return op;
  endfunction

  function automatic snp_resp_t respond(input snp_op_e op, input logic hit,
                                        input logic [1:0] st, input logic burst,
                                        input logic ci, input logic busy);
    snp_resp_t r;
    logic      keep;
    r.nxt   = st;
    r.upd   = 1'b0;
    r.retry = 1'b0;
    r.push  = 1'b0;
    keep    = (op == OP_READ) && !burst && ci;
    if (hit && op != OP_NONE) begin
      if (op == OP_KILL) begin
        r.nxt = ST_INV;
        r.upd = 1'b1;
      end else if (st == ST_MOD) begin
        r.retry = 1'b1;
        if (!busy) begin
          r.push = 1'b1;
          r.upd  = 1'b1;
          r.nxt  = keep ? ST_EXC : ST_INV;
        end
      end else begin
        r.upd = 1'b1;
        r.nxt = keep ? ST_EXC : ST_INV;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mei_tag_array.sv
module mei_tag_array
  import snoop_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [1:0]       lk_state,
  input  logic [IDX_W-1:0] pr_idx,
  input  logic [TAG_W-1:0] pr_tag,
  output logic [1:0]       pr_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [1:0]       wr_state
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [1:0]       st_q  [DEPTH];
  logic [DEPTH-1:0] wr_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        st_q[g]  <= ST_INV;
      end else if (wr_sel[g]) begin
        tag_q[g] <= wr_tag;
        st_q[g]  <= wr_state;
      end
    end
  end

  assign lk_state = st_q[lk_idx];
  assign lk_hit   = (tag_q[lk_idx] == lk_tag) && state_live(lk_state);
  assign pr_state = ((tag_q[pr_idx] == pr_tag) && state_live(st_q[pr_idx]))
                    ? st_q[pr_idx] : ST_INV;
endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
  import snoop_pkg::*;
(
  input  logic [4:0] tt,
  input  logic       burst,
  input  logic       ci,
  input  logic       hit,
  input  logic [1:0] state,
  input  logic       busy,
  output snp_op_e    op,
  output snp_resp_t  resp
);
  assign op   = decode_tt(tt);
  assign resp = respond(op, hit, state, burst, ci, busy);
endmodule

// File: rtl/push_ctl.sv
module push_ctl #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] start_line,
  input  logic              ack,
  output logic              req,
  output logic [LINE_W-1:0] line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      line <= '0;
    end else if (start) begin
      req  <= 1'b1;
      line <= start_line;
    end else if (req && ack) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_reg.sv
module rsv_reg #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [LINE_W-1:0] set_line,
  input  logic              clr_any,
  input  logic              clr_match,
  input  logic [LINE_W-1:0] snp_line,
  output logic              valid,
  output logic [LINE_W-1:0] line
);
  logic clr;
  assign clr = clr_any || (clr_match && (snp_line == line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      line  <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
      line  <= set_line;
    end
  end
endmodule

// File: rtl/snoop_resp_ctl.sv
module snoop_resp_ctl
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [4:0]        snp_tt,
  input  logic              snp_burst,
  input  logic              snp_ci,
  output logic              snp_retry,
  output logic              push_req,
  output logic [ADDR_W-1:0] push_addr,
  input  logic              push_ack,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic              rsv_set,
  input  logic [ADDR_W-1:0] rsv_addr,
  output logic              rsv_valid,
  output logic [ADDR_W-1:0] rsv_line_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [1:0]        probe_state
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  // address fields
  logic [LINE_W-1:0] s_line, f_line, r_line, p_line;
  logic [IDX_W-1:0]  s_idx, f_idx, p_idx;
  logic [TAG_W-1:0]  s_tag, f_tag, p_tag;

  assign s_line = snp_addr[ADDR_W-1:OFF_W];
  assign f_line = fill_addr[ADDR_W-1:OFF_W];
  assign r_line = rsv_addr[ADDR_W-1:OFF_W];
  assign p_line = probe_addr[ADDR_W-1:OFF_W];
  assign s_idx  = s_line[IDX_W-1:0];
  assign f_idx  = f_line[IDX_W-1:0];
  assign p_idx  = p_line[IDX_W-1:0];
  assign s_tag  = s_line[LINE_W-1:IDX_W];
  assign f_tag  = f_line[LINE_W-1:IDX_W];
  assign p_tag  = p_line[LINE_W-1:IDX_W];

  logic unused_off;
  assign unused_off = ^{snp_addr[OFF_W-1:0], fill_addr[OFF_W-1:0],
                        rsv_addr[OFF_W-1:0], probe_addr[OFF_W-1:0]};

  // named internal events, used by the checker
  logic      ev_hit;
  logic [1:0] lk_state;
  snp_op_e   ev_op;
  snp_resp_t ev_resp;
  logic      ev_op_kill, ev_op_flush, ev_push_start, ev_fill_wr;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [1:0]        wr_state;
  logic [LINE_W-1:0] push_line, rsv_line;

  mei_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (s_idx),
    .lk_tag   (s_tag),
    .lk_hit   (ev_hit),
    .lk_state (lk_state),
    .pr_idx   (p_idx),
    .pr_tag   (p_tag),
    .pr_state (probe_state),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_state (wr_state)
  );

  snoop_decide u_dec (
    .tt    (snp_tt),
    .burst (snp_burst),
    .ci    (snp_ci),
    .hit   (ev_hit),
    .state (lk_state),
    .busy  (push_req),
    .op    (ev_op),
    .resp  (ev_resp)
  );

  assign ev_op_kill    = snp_valid && (ev_op == OP_KILL);
  assign ev_op_flush   = snp_valid && (ev_op == OP_FLUSH);
  assign ev_push_start = snp_valid && ev_resp.push;
  assign ev_fill_wr    = fill_valid && !snp_valid;

  // one write port: snoop update has priority over a fill
  assign wr_en    = (snp_valid && ev_resp.upd) || ev_fill_wr;
  assign wr_idx   = snp_valid ? s_idx : f_idx;
  assign wr_tag   = snp_valid ? s_tag : f_tag;
  assign wr_state = snp_valid ? ev_resp.nxt : fill_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snp_retry <= 1'b0;
    else        snp_retry <= snp_valid && ev_resp.retry;
  end

  push_ctl #(.LINE_W(LINE_W)) u_push (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_push_start),
    .start_line (s_line),
    .ack        (push_ack),
    .req        (push_req),
    .line       (push_line)
  );

  rsv_reg #(.LINE_W(LINE_W)) u_rsv (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (rsv_set),
    .set_line  (r_line),
    .clr_any   (ev_op_flush),
    .clr_match (ev_op_kill),
    .snp_line  (s_line),
    .valid     (rsv_valid),
    .line      (rsv_line)
  );

  assign push_addr     = {push_line, {OFF_W{1'b0}}};
  assign rsv_line_addr = {rsv_line, {OFF_W{1'b0}}};
endmodule

// File: rtl/snoop_resp_chk.sv
module snoop_resp_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_valid,
  input logic              snp_retry,
  input logic              push_req,
  input logic              push_ack,
  input logic [ADDR_W-1:0] push_addr,
  input logic              rsv_valid,
  input logic              ev_hit,
  input logic              ev_op_kill,
  input logic              ev_op_flush
);
  AST_RETRY_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> $past(snp_valid));                                  // R8
  AST_MISS_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !ev_hit) |=> !snp_retry);                           // R7
  AST_KILL_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_kill |=> !snp_retry);                                       // R2
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !push_ack) |=> (push_req && $stable(push_addr)));    // R8
  AST_PUSH_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_req) |-> snp_retry);                                   // R8
  AST_FLUSH_CLEARS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_flush |=> !rsv_valid);                                      // R6
endmodule

bind snoop_resp_ctl snoop_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snp_valid   (snp_valid),
  .snp_retry   (snp_retry),
  .push_req    (push_req),
  .push_ack    (push_ack),
  .push_addr   (push_addr),
  .rsv_valid   (rsv_valid),
  .ev_hit      (ev_hit),
  .ev_op_kill  (ev_op_kill),
  .ev_op_flush (ev_op_flush)
);

// File: tb/sim_snoop_resp_ctl.sv
`timescale 1ns/1ps
module sim_snoop_resp_ctl;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 5;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 16;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snp_valid = 1'b0, snp_burst = 1'b0, snp_ci = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0, fill_addr = '0, rsv_addr = '0, probe_addr = '0;
  logic [4:0] snp_tt = '0;
  logic push_ack = 1'b0, fill_valid = 1'b0, rsv_set = 1'b0;
  logic [1:0] fill_state = '0;
  logic snp_retry, push_req, rsv_valid;
  logic [ADDR_W-1:0] push_addr, rsv_line_addr;
  logic [1:0] probe_state;

  always #2.5 clk = ~clk;

  snoop_resp_ctl u0 (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_tt(snp_tt), .snp_burst(snp_burst), .snp_ci(snp_ci),
    .snp_retry(snp_retry), .push_req(push_req), .push_addr(push_addr),
    .push_ack(push_ack), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_state(fill_state), .rsv_set(rsv_set), .rsv_addr(rsv_addr),
    .rsv_valid(rsv_valid), .rsv_line_addr(rsv_line_addr),
    .probe_addr(probe_addr), .probe_state(probe_state)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model
  logic [TAG_W-1:0]  m_tag [DEPTH];
  logic [1:0]        m_st  [DEPTH];
  logic              m_rv = 0, m_pend = 0, m_retry = 0;
  logic [ADDR_W-1:0] m_ra = '0, m_pa = '0;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // 1 kill, 2 read, 3 ownership, 4 flush, 0 no effect
  function automatic int kind(input logic [4:0] tt);
    if (tt == 5'b00110) return 1;
    if (tt[2:0] == 3'b010 && tt[3] && !tt[4]) return 2;
    if (tt == 5'b11010) return 2;
    if (tt[2:0] == 3'b110 && tt[3]) return 3;
    if (tt == 5'b10010) return 4;
    return 0;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int tg, input int ix, input int off);
    return {TAG_W'(tg), IDX_W'(ix), OFF_W'(off)};
  endfunction

  function automatic logic [ADDR_W-1:0] ln(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [1:0] m_probe(input logic [ADDR_W-1:0] a);
    int ix;
    ix = int'(a[OFF_W +: IDX_W]);
    if (m_tag[ix] == a[ADDR_W-1 -: TAG_W] && (m_st[ix] == 2'b01 || m_st[ix] == 2'b11))
      return m_st[ix];
    return 2'b00;
  endfunction

  task automatic step(input logic sv, input logic [ADDR_W-1:0] a, input logic [4:0] tt,
                      input logic bu, input logic ci, input logic fv,
                      input logic [ADDR_W-1:0] fa, input logic [1:0] fs,
                      input logic rs, input logic [ADDR_W-1:0] ra, input logic ak);
    int    ix, k;
    logic  hit, start, keep, clr;
    string rq, rrq;
    snp_valid = sv; snp_addr = a; snp_tt = tt; snp_burst = bu; snp_ci = ci;
    fill_valid = fv; fill_addr = fa; fill_state = fs;
    rsv_set = rs; rsv_addr = ra; push_ack = ak;
    @(posedge clk);
    ix = int'(a[OFF_W +: IDX_W]);
    k = kind(tt);
    hit = (m_probe(a) != 2'b00);
    keep = (k == 2) && !bu && ci;
    start = 0;
    m_retry = 0;
    rq = "R11";
    if (sv) begin
      if (!hit || k == 0) rq = "R7";
      else if (k == 1) rq = "R2";
      else if (k == 2) rq = keep ? "R3" : "R4";
      else rq = "R5";
      if (sv && hit && k == 1) m_st[ix] = 2'b00;
      else if (sv && hit && k != 0) begin
        if (m_st[ix] == 2'b11) begin
          m_retry = 1;
          if (m_pend) rq = "R9";
          else begin
            start = 1;
            m_st[ix] = keep ? 2'b01 : 2'b00;
          end
        end else m_st[ix] = keep ? 2'b01 : 2'b00;
      end
    end
    if (m_pend && ak) m_pend = 0;
    if (start) begin m_pend = 1; m_pa = ln(a); end
    if (fv && !sv) begin
      m_tag[int'(fa[OFF_W +: IDX_W])] = fa[ADDR_W-1 -: TAG_W];
      m_st[int'(fa[OFF_W +: IDX_W])]  = fs;
    end
    clr = sv && (k == 4 || (k == 1 && ln(a) == m_ra));
    rrq = (k == 4 && sv) ? "R6" : (k == 1 && sv) ? "R10" : "R12";
    if (clr) m_rv = 0;
    else if (rs) begin m_rv = 1; m_ra = ln(ra); end
    @(negedge clk);
    snp_valid = 0; fill_valid = 0; rsv_set = 0; push_ack = 0;
    probe_addr = (!sv && fv) ? fa : a;
    #0.5;
    chk(rq, "retry", 64'(snp_retry), 64'(m_retry));
    chk("R8", "push_req", 64'(push_req), 64'(m_pend));
    if (m_pend) chk("R8", "push_addr", 64'(push_addr), 64'(m_pa));
    chk(rrq, "rsv_valid", 64'(rsv_valid), 64'(m_rv));
    if (m_rv) chk(rrq, "rsv_line", 64'(rsv_line_addr), 64'(m_ra));
    chk(rq, "state", 64'(probe_state), 64'(m_probe(probe_addr)));
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    step(0, '0, 5'b0, 0, 0, 1, a, s, 0, '0, 0);
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input logic [4:0] tt,
                       input logic bu, input logic ci);
    step(1, a, tt, bu, ci, 0, '0, 2'b00, 0, '0, 0);
  endtask

  task automatic idle(input logic ak);
    step(0, '0, 5'b0, 0, 0, 0, '0, 2'b00, 0, '0, ak);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] codes [10];
    codes = '{5'b00110, 5'b01010, 5'b11010, 5'b01110, 5'b11110,
              5'b10010, 5'b10110, 5'b00011, 5'b00111, 5'b00000};
    void'($urandom(32'd7321));
    for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_st[i] = 2'b00; end
    repeat (3) @(negedge clk);
    probe_addr = mk(0, 0, 0);
    #0.5;
    chk("R11", "reset retry", 64'(snp_retry), 0);
    chk("R11", "reset push", 64'(push_req), 0);
    chk("R11", "reset rsv", 64'(rsv_valid), 0);
    chk("R11", "reset state", 64'(probe_state), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: atomic read on Modified behaves as a read
    fill(mk(1, 3, 0), 2'b11);
    snoop(mk(1, 3, 8), 5'b11010, 1, 0);
    chk("R1", "atomic read retry", 64'(snp_retry), 1);
    chk("R4", "burst read M to I", 64'(probe_state), 0);
    idle(1);
    // R3: single-beat inhibited read keeps Exclusive
    fill(mk(2, 5, 0), 2'b01);
    snoop(mk(2, 5, 4), 5'b01010, 0, 1);
    chk("R3", "E stays E", 64'(probe_state), 64'(2'b01));
    // R3: Modified goes Exclusive with push
    fill(mk(2, 6, 0), 2'b11);
    snoop(mk(2, 6, 0), 5'b01010, 0, 1);
    chk("R3", "M to E", 64'(probe_state), 64'(2'b01));
    idle(1);
    // R10: reservation cleared by kill on same line, other offset
    step(0, '0, 5'b0, 0, 0, 0, '0, 2'b00, 1, mk(3, 9, 28), 0);
    snoop(mk(3, 9, 4), 5'b00110, 1, 0);
    chk("R10", "kill clears rsv", 64'(rsv_valid), 0);
    // R6: flush to an unrelated missing line clears reservation
    step(0, '0, 5'b0, 0, 0, 0, '0, 2'b00, 1, mk(3, 9, 0), 0);
    snoop(mk(7, 1, 0), 5'b10010, 1, 0);
    chk("R6", "flush clears rsv", 64'(rsv_valid), 0);
    // R7: reserved code on a Modified line
    fill(mk(1, 2, 0), 2'b11);
    snoop(mk(1, 2, 0), 5'b10110, 1, 0);
    chk("R7", "reserved no retry", 64'(snp_retry), 0);
    chk("R7", "reserved keeps M", 64'(probe_state), 64'(2'b11));
    // R9: second dirty hit while push pending
    fill(mk(1, 4, 0), 2'b11);
    snoop(mk(1, 2, 0), 5'b01110, 1, 0);
    snoop(mk(1, 4, 0), 5'b01110, 1, 0);
    chk("R9", "busy retry", 64'(snp_retry), 1);
    chk("R9", "busy keeps M", 64'(probe_state), 64'(2'b11));
    idle(1);
    idle(0);
    // R11: fill ignored during a snoop
    step(1, mk(5, 7, 0), 5'b01010, 1, 0, 1, mk(5, 8, 0), 2'b01, 0, '0, 0);
    probe_addr = mk(5, 8, 0);
    #0.5;
    chk("R11", "fill ignored", 64'(probe_state), 0);
    // R12: clear wins over set in the same cycle
    step(1, mk(6, 0, 0), 5'b10010, 1, 0, 0, '0, 2'b00, 1, mk(6, 0, 0), 0);
    chk("R12", "clear wins", 64'(rsv_valid), 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic sv, fv, rs, ak;
      sv = ($urandom % 10) < 6;
      fv = ($urandom % 10) < 4;
      rs = ($urandom % 10) < 2;
      ak = ($urandom % 10) < 3;
      step(sv, mk($urandom % 2, $urandom % 8, $urandom % 32),
           ($urandom % 8 == 0) ? 5'($urandom) : codes[$urandom % 10],
           1'($urandom), 1'($urandom), fv,
           mk($urandom % 2, $urandom % 8, $urandom % 32), 2'($urandom),
           rs, mk($urandom % 2, $urandom % 8, $urandom % 32), ak);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule